// File: doc/BRIEF.md
# Slice-Compare Memory Self-Test Controller

This controller tests a set of on-chip RAM groups with a four-element march. All groups share one address and write-data bus, and each group has its own select line and its own read-data bus. The groups are tested one after another in ascending order. A group's word can be much wider than the comparator. After the single read of a word, the controller latches it and checks it one narrow data slice per cycle, starting from the lowest slice.

The first mismatch stops the engine. It records the group, the slice index and the address, raises a sticky fail flag and waits. Software issues a resume code to carry on from the slice after the one that failed. The fail flag survives a resume, and only a start code clears it. When the final march element of the last group completes, a done flag is raised.

Top module: `mbist_engine`

## Requirements
- R1: While reset is applied and right after it, `st_done`, `st_fail` and `st_halted` are 0 and no bit of `mem_cs` is set.
- R2: A control write with code 0x1 is accepted from any state. In the next cycle it clears done, fail and halted, and the engine then begins at group 0, address 0 with the first march element.
- R3: For each group, in ascending group order, the memory-port operations follow this sequence: write 0 at every address going up; read then write all-ones at every address going up; read then write 0 at every address going down; read at every address going down. At most one `mem_cs` bit is set in any cycle, and every write word is all zeros or all ones.
- R4: Each read is issued once. Its data is taken one cycle after the read cycle, and its slices are compared in successive cycles from slice 0 upward. Slice k holds word bits [k*SLICE_W+SLICE_W-1 : k*SLICE_W].
- R5: When a slice differs from the value the current element expects, the engine halts with `st_halted` = 1 and `st_fail` = 1. It makes no memory access until it is resumed or restarted.
- R6: When a halt occurs, `st_fail_grp`, `st_fail_slice` and `st_fail_addr` hold the group, the slice index and the address of the mismatch. They stay stable for as long as the halt lasts.
- R7: Control code 0x2 written during a halt resumes the engine at the slice after the failing one. If the failing slice was the last one, the element goes on to its write or to the next address. The same slice of the same read is never reported twice, and the operation sequence of R3 is not altered.
- R8: `st_fail` stays 1 through resumes and through completion, until a start write clears it.
- R9: `st_done` becomes 1 after the last read of the last group and stays 1 until a start write. It is never 1 in the same cycle as `st_halted`.
- R10: A control write with any code other than 0x1 or 0x2 has no effect. A 0x2 write when the engine is not halted also has no effect.
- R11: A bit whose read value is stuck at 1 halts the engine twice, once in the second element and once in the fourth. A bit whose read value is stuck at 0 halts it once, in the third element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_code | input | CODE_W | Control code: 0x1 start, 0x2 resume |
| st_done | output | 1 | All groups tested |
| st_fail | output | 1 | Sticky mismatch flag |
| st_halted | output | 1 | Engine stopped on a mismatch |
| st_fail_grp | output | GW | Group of the latest mismatch |
| st_fail_slice | output | SLW | Slice index of the latest mismatch |
| st_fail_addr | output | AW | Address of the latest mismatch |
| mem_cs | output | GROUPS | Per-group access select |
| mem_we | output | 1 | Write enable (0 means read) |
| mem_addr | output | AW | Shared word address |
| mem_wdata | output | WORD_W | Shared write data |
| mem_rdata | input | GROUPS*WORD_W | Read data, group g at bits [g*WORD_W +: WORD_W], valid one cycle after the read |

## Verification
The bench builds the engine with two groups of four 16-bit words and a 4-bit comparator, which gives four slices per word. At that size every group, address and bit position can be swept with a stuck-at-1 fault and with a stuck-at-0 fault. Each of the 256 runs must produce the expected halt count and the expected group, slice and address, which bench arithmetic derives from the bit index. The full memory-port operation list of every run is compared with a list the bench generates from the march definition. Directed runs cover two faults in different slices of one word, two faults in the same slice, restart during a run and during a halt, and ignored control codes.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CAPT,
        ST_CMP,
        ST_POST,
        ST_NEXT,
        ST_HALT,
        ST_DONE
    } state_t;

    // March elements, executed in this order
    typedef enum logic [1:0] {
        EL_FILL    = 2'd0,   // w0, ascending
        EL_UP_R0W1 = 2'd1,   // r0 then w1, ascending
        EL_DN_R1W0 = 2'd2,   // r1 then w0, descending
        EL_DN_R0   = 2'd3    // r0, descending
    } elem_t;

    localparam int unsigned CODE_START  = 1;
    localparam int unsigned CODE_RESUME = 2;

    function automatic logic elem_has_read(elem_t e);
        return e != EL_FILL;
    endfunction

    function automatic logic elem_has_write(elem_t e);
        return e != EL_DN_R0;
    endfunction

    function automatic logic elem_descending(elem_t e);
        return (e == EL_DN_R1W0) || (e == EL_DN_R0);
    endfunction

    function automatic logic elem_read_ones(elem_t e);
        return e == EL_DN_R1W0;
    endfunction

    function automatic logic elem_write_ones(elem_t e);
        return e == EL_UP_R0W1;
    endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq
    import mbist_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int DEPTH  = 16,
    parameter int GW     = 2,
    parameter int AW     = 4
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [GW-1:0] grp,
    output elem_t         elem,
    output elem_t         next_elem,
    output logic [AW-1:0] addr,
    output logic          seq_last
);

    localparam logic [AW-1:0] ADDR_TOP = AW'(DEPTH - 1);
    localparam logic [GW-1:0] GRP_TOP  = GW'(GROUPS - 1);

    logic last_addr;

    assign last_addr = elem_descending(elem) ? (addr == '0) : (addr == ADDR_TOP);
    assign seq_last  = last_addr && (elem == EL_DN_R0) && (grp == GRP_TOP);

    always_comb begin
        next_elem = elem;
        if (last_addr) begin
            unique case (elem)
                EL_FILL:    next_elem = EL_UP_R0W1;
                EL_UP_R0W1: next_elem = EL_DN_R1W0;
                EL_DN_R1W0: next_elem = EL_DN_R0;
                EL_DN_R0:   next_elem = EL_FILL;
                default:    next_elem = EL_FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grp  <= '0;
            elem <= EL_FILL;
            addr <= '0;
        end else if (clear) begin
            grp  <= '0;
            elem <= EL_FILL;
            addr <= '0;
        end else if (step) begin
            elem <= next_elem;
            if (last_addr) begin
                addr <= elem_descending(next_elem) ? ADDR_TOP : '0;
                if (elem == EL_DN_R0) begin
                    grp <= (grp == GRP_TOP) ? '0 : grp + GW'(1);
                end
            end else begin
                addr <= elem_descending(elem) ? addr - AW'(1) : addr + AW'(1);
            end
        end
    end

endmodule

// File: rtl/mbist_slice_cmp.sv
module mbist_slice_cmp #(
    parameter int WORD_W  = 128,
    parameter int SLICE_W = 32,
    parameter int NSLICE  = 4,
    parameter int SLW     = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [WORD_W-1:0] rdata,
    input  logic [SLW-1:0]    slice_sel,
    input  logic              expect_ones,
    output logic              mismatch
);

    logic [WORD_W-1:0]               word_q;
    logic [NSLICE-1:0][SLICE_W-1:0]  slices;
    logic [SLICE_W-1:0]              cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (capture) begin
            word_q <= rdata;
        end
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        assign slices[i] = word_q[i*SLICE_W +: SLICE_W];
    end

    always_comb begin
        cur = '0;
        for (int i = 0; i < NSLICE; i++) begin
            if (slice_sel == SLW'(i)) cur = slices[i];
        end
    end

    assign mismatch = cur != {SLICE_W{expect_ones}};

endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
    import mbist_pkg::*;
#(
    parameter int GROUPS  = 4,
    parameter int DEPTH   = 16,
    parameter int WORD_W  = 128,
    parameter int SLICE_W = 32,
    parameter int CODE_W  = 4,
    localparam int NSLICE = WORD_W / SLICE_W,
    localparam int AW     = (DEPTH  > 1) ? $clog2(DEPTH)  : 1,
    localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int SLW    = (NSLICE > 1) ? $clog2(NSLICE) : 1
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctrl_wr,
    input  logic [CODE_W-1:0]        ctrl_code,
    output logic                     st_done,
    output logic                     st_fail,
    output logic                     st_halted,
    output logic [GW-1:0]            st_fail_grp,
    output logic [SLW-1:0]           st_fail_slice,
    output logic [AW-1:0]            st_fail_addr,
    output logic [GROUPS-1:0]        mem_cs,
    output logic                     mem_we,
    output logic [AW-1:0]            mem_addr,
    output logic [WORD_W-1:0]        mem_wdata,
    input  logic [GROUPS*WORD_W-1:0] mem_rdata
);

    localparam logic [SLW-1:0] SLICE_TOP = SLW'(NSLICE - 1);

    state_t          state_q, state_d;
    logic [SLW-1:0]  slice_q, slice_d;

    logic [GW-1:0]   grp;
    elem_t           elem, next_elem;
    logic [AW-1:0]   addr;
    logic            seq_last;
    logic            seq_step;
    logic            mismatch;
    logic            do_start, do_resume;
    logic            access;
    logic [WORD_W-1:0] rd_sel;

    assign do_start  = ctrl_wr && (ctrl_code == CODE_W'(CODE_START));
    assign do_resume = ctrl_wr && (ctrl_code == CODE_W'(CODE_RESUME)) && (state_q == ST_HALT);
    assign seq_step  = (state_q == ST_NEXT) && !seq_last && !do_start;

    mbist_addr_seq #(
        .GROUPS (GROUPS),
        .DEPTH  (DEPTH),
        .GW     (GW),
        .AW     (AW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (do_start),
        .step      (seq_step),
        .grp       (grp),
        .elem      (elem),
        .next_elem (next_elem),
        .addr      (addr),
        .seq_last  (seq_last)
    );

    always_comb begin
        rd_sel = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (grp == GW'(g)) rd_sel = mem_rdata[g*WORD_W +: WORD_W];
        end
    end

    mbist_slice_cmp #(
        .WORD_W  (WORD_W),
        .SLICE_W (SLICE_W),
        .NSLICE  (NSLICE),
        .SLW     (SLW)
    ) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (state_q == ST_CAPT),
        .rdata       (rd_sel),
        .slice_sel   (slice_q),
        .expect_ones (elem_read_ones(elem)),
        .mismatch    (mismatch)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        slice_d = slice_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
            end
            ST_WRITE: state_d = ST_NEXT;
            ST_READ:  state_d = ST_CAPT;
            ST_CAPT: begin
                state_d = ST_CMP;
                slice_d = '0;
            end
            ST_CMP: begin
                if (mismatch)                  state_d = ST_HALT;
                else if (slice_q == SLICE_TOP) state_d = ST_POST;
                else                           slice_d = slice_q + SLW'(1);
            end
            ST_POST: state_d = elem_has_write(elem) ? ST_WRITE : ST_NEXT;
            ST_NEXT: begin
                if (seq_last) state_d = ST_DONE;
                else          state_d = elem_has_read(next_elem) ? ST_READ : ST_WRITE;
            end
            ST_HALT: begin
                if (do_resume) begin
                    if (slice_q == SLICE_TOP) begin
                        state_d = ST_POST;
                    end else begin
                        state_d = ST_CMP;
                        slice_d = slice_q + SLW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (do_start) begin
            state_d = ST_WRITE;
            slice_d = '0;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slice_q <= '0;
        end else begin
            state_q <= state_d;
            slice_q <= slice_d;
        end
    end

    // Status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_done       <= 1'b0;
            st_fail       <= 1'b0;
            st_fail_grp   <= '0;
            st_fail_slice <= '0;
            st_fail_addr  <= '0;
        end else if (do_start) begin
            st_done       <= 1'b0;
            st_fail       <= 1'b0;
            st_fail_grp   <= '0;
            st_fail_slice <= '0;
            st_fail_addr  <= '0;
        end else begin
            if (state_q == ST_CMP && mismatch) begin
                st_fail       <= 1'b1;
                st_fail_grp   <= grp;
                st_fail_slice <= slice_q;
                st_fail_addr  <= addr;
            end
            if (state_q == ST_NEXT && seq_last) begin
                st_done <= 1'b1;
            end
        end
    end

    // Memory port outputs
    assign access    = (state_q == ST_WRITE) || (state_q == ST_READ);
    assign st_halted = state_q == ST_HALT;
    assign mem_we    = state_q == ST_WRITE;
    assign mem_addr  = addr;
    assign mem_wdata = {WORD_W{elem_write_ones(elem)}};

    for (genvar g = 0; g < GROUPS; g++) begin : g_cs
        assign mem_cs[g] = access && (grp == GW'(g));
    end

endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
    parameter int GROUPS = 4,
    parameter int CODE_W = 4,
    parameter int GW     = 2,
    parameter int SLW    = 2,
    parameter int AW     = 4
)(
    input logic              clk,
    input logic              rst_n,
    input logic              ctrl_wr,
    input logic [CODE_W-1:0] ctrl_code,
    input logic              st_done,
    input logic              st_fail,
    input logic              st_halted,
    input logic [GW-1:0]     st_fail_grp,
    input logic [SLW-1:0]    st_fail_slice,
    input logic [AW-1:0]     st_fail_addr,
    input logic [GROUPS-1:0] mem_cs
);

    logic start_wr, other_wr;
    assign start_wr = ctrl_wr && (ctrl_code == CODE_W'(1));
    assign other_wr = ctrl_wr && (ctrl_code != CODE_W'(1)) && (ctrl_code != CODE_W'(2));

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!st_done && !st_fail && !st_halted && mem_cs == '0));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (!st_done && !st_fail && !st_halted));

    assert_one_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mem_cs));

    assert_halt_no_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_halted |-> mem_cs == '0);

    assert_halt_has_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_halted) |-> st_fail);

    assert_halt_info_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_halted && !ctrl_wr) |=> (st_halted && $stable(st_fail_grp)
                                     && $stable(st_fail_slice) && $stable(st_fail_addr)));

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_fail && !start_wr) |=> st_fail);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_done && !start_wr) |=> st_done);

    assert_done_not_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_done && st_halted));

    assert_bad_code_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_halted && other_wr) |=> st_halted);

endmodule

bind mbist_engine mbist_engine_chk #(
    .GROUPS (GROUPS),
    .CODE_W (CODE_W),
    .GW     (GW),
    .SLW    (SLW),
    .AW     (AW)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr       (ctrl_wr),
    .ctrl_code     (ctrl_code),
    .st_done       (st_done),
    .st_fail       (st_fail),
    .st_halted     (st_halted),
    .st_fail_grp   (st_fail_grp),
    .st_fail_slice (st_fail_slice),
    .st_fail_addr  (st_fail_addr),
    .mem_cs        (mem_cs)
);

// File: tb/mbist_engine_test.sv
module mbist_engine_test;

    localparam int G = 2, D = 4, W = 16, SW = 4;
    localparam int AW = 2, GW = 1, SLW = 2, CW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic            ctrl_wr = 1'b0;
    logic [CW-1:0]   ctrl_code = '0;
    logic            st_done, st_fail, st_halted;
    logic [GW-1:0]   st_fail_grp;
    logic [SLW-1:0]  st_fail_slice;
    logic [AW-1:0]   st_fail_addr;
    logic [G-1:0]    mem_cs;
    logic            mem_we;
    logic [AW-1:0]   mem_addr;
    logic [W-1:0]    mem_wdata;
    logic [G*W-1:0]  mem_rdata;

    mbist_engine #(.GROUPS(G), .DEPTH(D), .WORD_W(W), .SLICE_W(SW), .CODE_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_code(ctrl_code),
        .st_done(st_done), .st_fail(st_fail), .st_halted(st_halted),
        .st_fail_grp(st_fail_grp), .st_fail_slice(st_fail_slice), .st_fail_addr(st_fail_addr),
        .mem_cs(mem_cs), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    int checks = 0, errors = 0;

    // Memory model with read-path stuck-at faults
    logic [W-1:0] ram [G][D];
    int f_en[2], f_g[2], f_a[2], f_b[2], f_v[2];

    function automatic logic [W-1:0] faulty(int g, int a, logic [W-1:0] d);
        logic [W-1:0] r = d;
        for (int i = 0; i < 2; i++)
            if (f_en[i] != 0 && f_g[i] == g && f_a[i] == a) r[f_b[i]] = f_v[i][0];
        return r;
    endfunction

    always @(posedge clk) begin
        for (int g = 0; g < G; g++) begin
            if (mem_cs[g]) begin
                if (mem_we) ram[g][mem_addr] <= mem_wdata;
                else mem_rdata[g*W +: W] <= faulty(g, int'(mem_addr), ram[g][mem_addr]);
            end
        end
    end

    // Expected memory-port operation list
    int exp_ops[$];
    int op_idx = 0, seq_err = 0;
    bit mon_en = 1'b0;

    function automatic int op_code(int g, int we, int d, int a);
        return g * 10000 + we * 1000 + d * 100 + a;
    endfunction

    task automatic build_ops();
        exp_ops.delete();
        for (int g = 0; g < G; g++) begin
            for (int a = 0; a < D; a++) exp_ops.push_back(op_code(g, 1, 0, a));
            for (int a = 0; a < D; a++) begin
                exp_ops.push_back(op_code(g, 0, 0, a));
                exp_ops.push_back(op_code(g, 1, 1, a));
            end
            for (int a = D - 1; a >= 0; a--) begin
                exp_ops.push_back(op_code(g, 0, 0, a));
                exp_ops.push_back(op_code(g, 1, 0, a));
            end
            for (int a = D - 1; a >= 0; a--) exp_ops.push_back(op_code(g, 0, 0, a));
        end
    endtask

    always @(negedge clk) begin
        int gs, c;
        if (mon_en && mem_cs != '0) begin
            gs = 0;
            for (int i = 0; i < G; i++) if (mem_cs[i]) gs = i;
            c = op_code(gs, mem_we ? 1 : 0, (mem_we && mem_wdata[0]) ? 1 : 0, int'(mem_addr));
            if ($countones(mem_cs) != 1) seq_err++;
            if (mem_we && mem_wdata != {W{mem_wdata[0]}}) seq_err++;
            if (op_idx >= exp_ops.size()) seq_err++;
            else if (exp_ops[op_idx] != c) seq_err++;
            op_idx++;
        end
    end

    task automatic check_eq(int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic ctrl(int c);
        @(negedge clk); #2;
        ctrl_wr = 1'b1; ctrl_code = CW'(c);
        @(negedge clk); #2;
        ctrl_wr = 1'b0; ctrl_code = '0;
    endtask

    task automatic start_run();
        @(negedge clk); #2;
        build_ops();
        op_idx = 0; seq_err = 0; mon_en = 1'b1;
        ctrl_wr = 1'b1; ctrl_code = CW'(1);
        @(negedge clk); #2;
        ctrl_wr = 1'b0; ctrl_code = '0;
    endtask

    task automatic wait_stop(output int kind);
        kind = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (st_halted) begin kind = 1; break; end
            if (st_done)   begin kind = 2; break; end
        end
    endtask

    function automatic int loc(int g, int s, int a);
        return g * 256 + s * 16 + a;
    endfunction

    task automatic expect_halt(int g, int s, int a);
        int k;
        wait_stop(k);
        check_eq(k, 1, "R5 halt on mismatch");
        check_eq(loc(int'(st_fail_grp), int'(st_fail_slice), int'(st_fail_addr)),
                 loc(g, s, a), "R6 fail location");
        ctrl(2);
        check_eq(int'(st_fail), 1, "R8 fail kept after resume");
    endtask

    task automatic finish_run(int exp_fail);
        int k;
        wait_stop(k);
        check_eq(k, 2, "R9 done after last group");
        check_eq(int'(st_fail), exp_fail, "R8 fail flag at end");
        check_eq(seq_err, 0, "R3 R7 operation order");
        check_eq(op_idx, exp_ops.size(), "R3 operation count");
        mon_en = 1'b0;
    endtask

    task automatic clear_faults();
        for (int i = 0; i < 2; i++) f_en[i] = 0;
    endtask

    task automatic set_fault(int i, int g, int a, int b, int v);
        f_en[i] = 1; f_g[i] = g; f_a[i] = a; f_b[i] = b; f_v[i] = v;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int nz, k, held;
        clear_faults();
        for (int g = 0; g < G; g++) for (int a = 0; a < D; a++) ram[g][a] = 16'hA5C3;

        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq({st_done, st_fail, st_halted, mem_cs}, 0, "R1 state during reset");
        #2 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_eq({st_done, st_fail, st_halted, mem_cs}, 0, "R1 idle after reset");

        // R3 R9: clean run
        start_run();
        finish_run(0);
        nz = 0;
        for (int g = 0; g < G; g++) for (int a = 0; a < D; a++) if (ram[g][a] != '0) nz++;
        check_eq(nz, 0, "R3 memory zero after march");
        repeat (5) @(negedge clk);
        check_eq(int'(st_done), 1, "R9 done holds");
        ctrl(2);
        ctrl(7);
        check_eq({st_done, st_halted}, 2, "R10 codes ignored while done");

        // R10: resume and bad codes while running
        start_run();
        repeat (10) @(negedge clk);
        ctrl(2); ctrl(0); ctrl(5); ctrl(15);
        check_eq(int'(st_halted), 0, "R10 no halt from ignored codes");
        finish_run(0);

        // R2: restart mid-run
        start_run();
        repeat (30) @(negedge clk);
        start_run();
        check_eq({st_done, st_fail, st_halted}, 0, "R2 start clears status");
        finish_run(0);

        // R4 R7: two faults in different slices of one word
        set_fault(0, 1, 2, 1, 1);
        set_fault(1, 1, 2, 13, 1);
        start_run();
        expect_halt(1, 0, 2); expect_halt(1, 3, 2);
        expect_halt(1, 0, 2); expect_halt(1, 3, 2);
        finish_run(1);
        clear_faults();

        // R7: two faults in one slice, reported once per read
        set_fault(0, 0, 3, 4, 1);
        set_fault(1, 0, 3, 6, 1);
        start_run();
        expect_halt(0, 1, 3);
        expect_halt(0, 1, 3);
        finish_run(1);
        clear_faults();

        // R5 R10 R2: hold during halt, ignored codes, restart from halt
        set_fault(0, 0, 1, 5, 1);
        start_run();
        wait_stop(k);
        check_eq(k, 1, "R5 halted");
        held = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (st_halted && mem_cs == '0) held++;
        end
        check_eq(held, 4, "R5 no access while halted");
        ctrl(3); ctrl(0);
        check_eq(int'(st_halted), 1, "R10 bad code keeps halt");
        check_eq(loc(int'(st_fail_grp), int'(st_fail_slice), int'(st_fail_addr)),
                 loc(0, 1, 1), "R6 location kept during halt");
        start_run();
        check_eq({st_done, st_fail, st_halted}, 0, "R2 start clears halt");
        expect_halt(0, 1, 1);
        expect_halt(0, 1, 1);
        finish_run(1);
        clear_faults();

        // R11 R6: sweep every group, address, bit and polarity
        for (int g = 0; g < G; g++)
            for (int a = 0; a < D; a++)
                for (int b = 0; b < W; b++)
                    for (int v = 0; v < 2; v++) begin
                        set_fault(0, g, a, b, v);
                        start_run();
                        expect_halt(g, b / SW, a);
                        if (v == 1) expect_halt(g, b / SW, a);
                        finish_run(1);
                        clear_faults();
                    end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule